// File: doc/BRIEF.md
# Bit-Masked General-Purpose Pin Port

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide register bus. Each pin has a direction bit that makes it an input or an output. The block drives an output-enable vector and an output-value vector toward the pad ring. It samples the pad levels through a two-stage synchroniser.

Pin data is reached through a window of word-aligned addresses rather than a single address. Address bits [9:2] form a per-pin mask that applies to both reads and writes. Software can therefore set, clear or sample any group of pins in one bus access, and it never needs a read-modify-write sequence. An interrupt-detection block may sit beside this one and watch the same synchronised levels, but it is not part of this block.

Top module: `gpio_mask_port`

## Requirements
- R1: The port has 8 pins and every register is 8 bits wide. The direction register is at byte offset 0x400. A 1 in bit n makes pin n an output, and `pin_oe` always equals the direction register.
- R2: While `rst_n` is low, the direction register, the stored output data and `rdata` are all zero.
- R3: The data window is the set of offsets whose bits [1:0] and [11:10] are zero (0x000 to 0x3FC). On a write there, mask = addr[9:2], and only the stored output bits whose mask bit is 1 take the value of `wdata`. All other stored bits keep their value.
- R4: A read in the data window returns 0 in every bit whose mask bit is clear. Each set bit returns the stored output bit for an output pin, or the synchronised pad level for an input pin.
- R5: Stored output data is written and kept whatever the pin's direction. `pin_out` always shows the stored data, so a pin drives its stored value as soon as its direction bit is set.
- R6: Any offset other than the data window and 0x400 is unmapped. This includes misaligned offsets and offsets with bit 11 set. A read of an unmapped offset returns 0, and a write to one changes neither `pin_oe` nor `pin_out`.
- R7: A write takes effect on the clock edge that samples `wr_en`. Read data appears on `rdata` after the edge that samples `rd_en`. After an edge where `rd_en` was low, `rdata` is 0.
- R8: Pad inputs pass through two flops before they are seen by a read. A read sampled on the same edge as a pad change returns the old level. A read sampled three or more edges after the change returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad levels, asynchronous to clk |
| pin_oe | output | 8 | Output enable per pin |
| pin_out | output | 8 | Output value per pin |

## Verification
The properties assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the address and write data are stable across the sampling edge. The stimulus keeps to this because every access is driven on the falling edge and lasts exactly one cycle, with the strobe dropped before the next access begins. Pad levels are changed only on falling edges, and several idle cycles pass before a read that expects the new level. The one exception is the directed case that deliberately reads on the same edge as a pad change.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Decoded class of a bus offset.
    typedef enum logic [1:0] {
        ACC_UNMAPPED = 2'd0,
        ACC_DATA     = 2'd1,
        ACC_DIR      = 2'd2
    } acc_kind_e;

    // Low offset bits that select a byte within a word.
    localparam int unsigned BYTE_SEL_W = 2;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 8,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [11:0] DIR_OFFSET = 12'h400
) (
    input  logic [ADDR_W-1:0]   addr,
    output acc_kind_e           kind,
    output logic [NUM_PINS-1:0] mask
);
    localparam int unsigned MASK_LSB = BYTE_SEL_W;
    localparam int unsigned MASK_MSB = MASK_LSB + NUM_PINS - 1;
    localparam int unsigned HI_LSB   = MASK_MSB + 1;
    localparam int unsigned HI_W     = ADDR_W - HI_LSB;

    logic             aligned;
    logic             in_window;
    logic [HI_W-1:0]  hi_bits;

    always_comb begin
        hi_bits   = addr[ADDR_W-1:HI_LSB];
        aligned   = (addr[BYTE_SEL_W-1:0] == '0);
        in_window = aligned && (hi_bits == '0);
        mask      = addr[MASK_MSB:MASK_LSB];
        if (in_window) begin
            kind = ACC_DATA;
        end else if (addr == ADDR_W'(DIR_OFFSET)) begin
            kind = ACC_DIR;
        end else begin
            kind = ACC_UNMAPPED;
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);
    logic [NUM_PINS-1:0] stage_d [SYNC_STAGES];
    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

    always_comb begin
        stage_d[0] = pin_async;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_flop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign pin_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  acc_kind_e           kind,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] dout
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] dout;
    } regs_t;

    regs_t regs_d;
    regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (kind)
                ACC_DATA: regs_d.dout = (regs_q.dout & ~mask) | (wdata & mask);
                ACC_DIR:  regs_d.dir  = wdata;
                default:  regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir  = regs_q.dir;
    assign dout = regs_q.dout;
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  acc_kind_e           kind,
    input  logic [NUM_PINS-1:0] mask,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] dout,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] rdata
);
    typedef struct packed {
        logic [NUM_PINS-1:0] rdata;
    } rd_t;

    rd_t                 rd_d;
    rd_t                 rd_q;
    logic [NUM_PINS-1:0] level;

    always_comb begin
        level    = (dir & dout) | (~dir & pin_sync);
        rd_d     = '0;
        if (rd_en) begin
            unique case (kind)
                ACC_DATA: rd_d.rdata = level & mask;
                ACC_DIR:  rd_d.rdata = dir;
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rdata;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [11:0] DIR_OFFSET  = 12'h400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    acc_kind_e           kind;
    logic [NUM_PINS-1:0] mask;
    logic [NUM_PINS-1:0] dir;
    logic [NUM_PINS-1:0] dout;
    logic [NUM_PINS-1:0] pin_sync;

    gpio_addr_decode #(
        .NUM_PINS   (NUM_PINS),
        .ADDR_W     (ADDR_W),
        .DIR_OFFSET (DIR_OFFSET)
    ) i_decode (
        .addr (addr),
        .kind (kind),
        .mask (mask)
    );

    gpio_pin_sync #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_port_regs #(
        .NUM_PINS (NUM_PINS)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .kind  (kind),
        .mask  (mask),
        .wdata (wdata),
        .dir   (dir),
        .dout  (dout)
    );

    gpio_read_path #(
        .NUM_PINS (NUM_PINS)
    ) i_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .kind     (kind),
        .mask     (mask),
        .dir      (dir),
        .dout     (dout),
        .pin_sync (pin_sync),
        .rdata    (rdata)
    );

    assign pin_oe  = dir;
    assign pin_out = dout;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int unsigned NUM_PINS   = 8,
    parameter int unsigned ADDR_W     = 12,
    parameter logic [11:0] DIR_OFFSET = 12'h400
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_PINS-1:0] wdata,
    input logic [NUM_PINS-1:0] rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out
);
    localparam int unsigned HI_LSB = NUM_PINS + 2;

    logic [NUM_PINS-1:0] c_mask;
    logic                c_win;
    logic                c_dir;

    assign c_mask = addr[NUM_PINS+1:2];
    assign c_win  = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:HI_LSB] == '0);
    assign c_dir  = (addr == ADDR_W'(DIR_OFFSET));

    // R2: state leaves reset cleared
    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && rdata == '0));

    // R3: masked write merges new and old bits
    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && c_win) |=> pin_out ==
            (($past(wdata) & $past(c_mask)) | ($past(pin_out) & ~$past(c_mask))));

    // R6: stored data moves only on a data-window write
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && c_win) |=> $stable(pin_out));

    // R1: direction moves only on a write to its offset
    assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && c_dir) |=> $stable(pin_oe));

    // R1: direction write lands one edge later
    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && c_dir) |=> pin_oe == $past(wdata));

    // R4: unmasked bits read as zero
    assert_read_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && c_win) |=> (rdata & ~$past(c_mask)) == '0);

    // R6: unmapped read yields zero
    assert_unmapped_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !c_win && !c_dir) |=> rdata == '0);

    // R7: idle cycle leaves zero read data
    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .DIR_OFFSET (DIR_OFFSET)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mask_port i_gpio_mask_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    // {is_read, offset, wdata_or_pins, expected}
    localparam int NVEC = 16;
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 12'h400, 8'hF0, 8'hF0},
        {1'b0, 12'h3FC, 8'hA5, 8'hA5},
        {1'b0, 12'h004, 8'h00, 8'hA4},
        {1'b0, 12'h200, 8'h00, 8'h24},
        {1'b0, 12'h028, 8'hFF, 8'h2E},
        {1'b0, 12'h000, 8'hFF, 8'h2E},
        {1'b0, 12'h404, 8'hFF, 8'h2E},
        {1'b0, 12'h3FD, 8'hFF, 8'h2E},
        {1'b1, 12'h3FC, 8'h0F, 8'h2F},
        {1'b1, 12'h3FC, 8'h00, 8'h20},
        {1'b1, 12'h004, 8'hFF, 8'h01},
        {1'b1, 12'h080, 8'h00, 8'h20},
        {1'b1, 12'h040, 8'hFF, 8'h00},
        {1'b1, 12'h400, 8'h00, 8'hF0},
        {1'b1, 12'h404, 8'hFF, 8'h00},
        {1'b1, 12'h800, 8'hFF, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] r);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 oe", pin_oe, 8'h00);
        check("R2 out", pin_out, 8'h00);
        check("R2 rdata", rdata, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic        is_rd;
            logic [11:0] a;
            logic [7:0]  d, e;
            {is_rd, a, d, e} = VEC[i];
            if (is_rd) begin
                set_pins(d);
                bus_read(a, r);
                if (a == 12'h400)      check("R1 dir read", r, e);
                else if (a == 12'h404 || a == 12'h800) check("R6 unmapped read", r, e);
                else                   check("R4 masked read", r, e);
            end else begin
                bus_write(a, d);
                if (a == 12'h400)      check("R1 dir write", pin_oe, e);
                else if (a == 12'h404 || a == 12'h3FD) check("R6 unmapped write", pin_out, e);
                else                   check("R3 masked write", pin_out, e);
            end
        end
        // R6: direction untouched by unmapped writes
        check("R6 dir kept", pin_oe, 8'hF0);

        // R5: data stored while inputs, driven once outputs
        bus_write(12'h400, 8'h00);
        bus_write(12'h3FC, 8'h5A);
        check("R5 out while input", pin_out, 8'h5A);
        check("R5 oe off", pin_oe, 8'h00);
        set_pins(8'h00);
        bus_read(12'h3FC, r);
        check("R4 input pins read pads", r, 8'h00);
        bus_write(12'h400, 8'hFF);
        bus_read(12'h3FC, r);
        check("R5 stored value driven", r, 8'h5A);
        check("R5 oe on", pin_oe, 8'hFF);

        // R7: rdata returns to zero after an idle cycle
        @(negedge clk);
        check("R7 idle rdata", rdata, 8'h00);

        // R8: synchroniser latency
        bus_write(12'h400, 8'h00);
        @(negedge clk);
        pin_in = 8'hFF; rd_en = 1'b1; addr = 12'h3FC;
        @(negedge clk);
        rd_en = 1'b0;
        check("R8 same-edge read old", rdata, 8'h00);
        repeat (3) @(negedge clk);
        bus_read(12'h3FC, r);
        check("R8 settled read new", r, 8'hFF);

        // R2: reset in mid-run clears state
        bus_write(12'h400, 8'h3C);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid reset oe", pin_oe, 8'h00);
        check("R2 mid reset out", pin_out, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule